// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

This block is an up/down counter that generates symmetric pulse-width modulation on a set of compare channels. The counter climbs one step per enabled timer tick until it reaches the period limit. It holds the limit for one tick and then falls back to zero. Because every new limit and compare value is applied only when the counter sits at zero, the rising and falling slopes of every period are equal. The pulses are therefore centred in the period, and the period length follows the programmed limit exactly.

Software writes the period limit and the per-channel compare values through a small write port. These writes land in shadow registers and take effect at the next visit to zero. A select input chooses whether the period limit comes from its own register or from the first channel's compare value. Each channel has a two-bit output mode: idle low, direct or complemented. Sticky event flags record the wrap at zero, the turn at the limit and each compare hit. Software clears a flag by writing a one to it.

Top module: `pwm_ds_timer`

## Requirements
- R1: After reset the counter counts up by one per enabled tick from 0 to the effective limit. It shows the limit for exactly one tick and then counts down by one per tick to 0, where it turns up again.
- R2: On cycles where `tick` is low the counter, the flags (apart from clearing) and the outputs keep their values.
- R3: With `top_src` = 0 the effective limit is the active limit register. With `top_src` = 1 it is the active compare value of channel 0.
- R4: An effective limit below 3 is treated as 3.
- R5: Writes go to shadow copies: address 0 is the limit register, address 1+i is channel i's compare value, other addresses are ignored. Shadow values move into the active copies only on an enabled tick at count 0, so a write in mid-period does not change the current period.
- R6: Flag bit 0 (wrap) is set by every enabled tick at count 0.
- R7: Flag bit 1 (limit turn) is set by an enabled tick at the limit, but only while `top_src` = 0.
- R8: Flag bit 2+i is set by every enabled tick on which the count equals channel i's active compare value. A compare value above the limit never sets it.
- R9: Output mode 2 (direct): a compare hit drives the channel output low when the next step is upward (including a hit at count 0) and high when the next step is downward (including a hit at the limit). A compare value of 0 therefore gives a constant low output, and a compare value equal to the limit gives a constant high output.
- R10: Output mode 3 gives the complement of mode 2.
- R11: Output modes 0 and 1 drive the channel output low.
- R12: A one in `flag_clr` clears that flag bit, and a zero has no effect. If a set and a clear fall in the same cycle, the set wins.
- R13: Reset gives count 0, all flags 0, active and shadow limit all ones and all compare values 0. Each channel's internal output level resets low, so mode 3 outputs read high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| top_src | input | 1 | Limit source: 0 limit register, 1 channel 0 compare |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (2) | Write address: 0 limit, 1+i channel i |
| wr_data | input | CNT_W (16) | Write data |
| out_mode | input | 2*N_CH (4) | Two mode bits per channel, channel i at bits 2i+1:2i |
| flag_clr | input | N_CH+2 (4) | Write-one-to-clear mask for the flags |
| count | output | CNT_W (16) | Current counter value |
| flags | output | N_CH+2 (4) | Sticky flags: bit 0 wrap, bit 1 limit turn, bit 2+i channel i hit |
| pwm_out | output | N_CH (2) | Channel outputs |

## Verification
The bench moves the limit in the middle of a period. A design that loaded shadows immediately would show an asymmetric period with the wrong peak. Compare values of 0 and of exactly the limit are driven to check that hits at the turning points resolve to constant levels. A design that used the current direction instead of the next one would toggle or stick at the wrong level. Limits of 1 and compare values above the limit check the clamp and the missing hit. A wrong clamp would produce a short or degenerate period, and a wrong hit test would set a compare flag that should stay clear. A clear that collides with a wrap event checks set priority, because a clear-wins design would lose the event.

// File: rtl/pwm_ds_pkg.sv
package pwm_ds_pkg;

   typedef enum logic [1:0] {
      OM_IDLE_A = 2'd0,
      OM_IDLE_B = 2'd1,
      OM_DIRECT = 2'd2,
      OM_COMPL  = 2'd3
   } out_mode_e;

   localparam int unsigned FLG_WRAP = 0;
   localparam int unsigned FLG_PEAK = 1;
   localparam int unsigned FLG_CMP0 = 2;

endpackage

// File: rtl/pwm_ds_regs.sv
// Shadow and active copies of the limit and compare values (R5, R13).
module pwm_ds_regs #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned N_CH   = 2,
   parameter int unsigned ADDR_W = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [CNT_W-1:0]             wr_data,
   input  logic                         load,
   output logic [CNT_W-1:0]             act_top,
   output logic [N_CH-1:0][CNT_W-1:0]   act_cmp
);

   localparam logic [ADDR_W-1:0] TOP_ADDR = '0;

   logic [CNT_W-1:0] shd_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_top <= '1;
      end else if (wr_en && (wr_addr == TOP_ADDR)) begin
         shd_top <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_top <= '1;
      end else if (load) begin
         act_top <= shd_top;
      end
   end

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_cmp
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ch + 1);
      logic [CNT_W-1:0] shd_q;
      logic [CNT_W-1:0] act_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shd_q <= '0;
         end else if (wr_en && (wr_addr == MY_ADDR)) begin
            shd_q <= wr_data;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_q <= '0;
         end else if (load) begin
            act_q <= shd_q;
         end
      end

      assign act_cmp[ch] = act_q;
   end

endmodule

// File: rtl/pwm_ds_counter.sv
// Up/down counter with the limit clamp (R1, R2, R4).
module pwm_ds_counter #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned MIN_TOP = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] top_sel,
   output logic [CNT_W-1:0] count,
   output logic             at_bottom,
   output logic             at_peak,
   output logic             next_up
);

   logic [CNT_W-1:0] lim;
   logic             up_q;

   if (MIN_TOP > 0) begin : g_clamp
      assign lim = (top_sel < CNT_W'(MIN_TOP)) ? CNT_W'(MIN_TOP) : top_sel;
   end else begin : g_raw
      assign lim = top_sel;
   end

   assign at_bottom = (count == '0);
   assign at_peak   = up_q && !at_bottom && (count >= lim);

   always_comb begin
      if (at_bottom) begin
         next_up = 1'b1;
      end else if (at_peak) begin
         next_up = 1'b0;
      end else begin
         next_up = up_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         up_q  <= 1'b0;
      end else if (tick) begin
         up_q  <= next_up;
         count <= next_up ? (count + CNT_W'(1)) : (count - CNT_W'(1));
      end
   end

endmodule

// File: rtl/pwm_ds_channel.sv
// One compare channel: hit detection, output level and output mode (R8 to R11).
module pwm_ds_channel
   import pwm_ds_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] cmp,
   input  logic             next_up,
   input  logic [1:0]       mode,
   output logic             hit,
   output logic             pin
);

   logic lvl_q;

   assign hit = tick && (count == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
      end else if (hit) begin
         lvl_q <= !next_up;
      end
   end

   always_comb begin
      case (out_mode_e'(mode))
         OM_DIRECT: pin = lvl_q;
         OM_COMPL:  pin = !lvl_q;
         default:   pin = 1'b0;
      endcase
   end

endmodule

// File: rtl/pwm_ds_flags.sv
// Sticky event flags with write-one-to-clear; set has priority (R12).
module pwm_ds_flags #(
   parameter int unsigned N_FLG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_FLG-1:0] set,
   input  logic [N_FLG-1:0] clr,
   output logic [N_FLG-1:0] flags
);

   for (genvar f = 0; f < N_FLG; f++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f_q <= 1'b0;
         end else if (set[f]) begin
            f_q <= 1'b1;
         end else if (clr[f]) begin
            f_q <= 1'b0;
         end
      end
      assign flags[f] = f_q;
   end

endmodule

// File: rtl/pwm_ds_timer.sv
module pwm_ds_timer
   import pwm_ds_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned N_CH    = 2,
   parameter int unsigned MIN_TOP = 3,
   parameter int unsigned ADDR_W  = $clog2(N_CH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                top_src,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [CNT_W-1:0]    wr_data,
   input  logic [2*N_CH-1:0]   out_mode,
   input  logic [N_CH+1:0]     flag_clr,
   output logic [CNT_W-1:0]    count,
   output logic [N_CH+1:0]     flags,
   output logic [N_CH-1:0]     pwm_out
);

   localparam int unsigned N_FLG = N_CH + 2;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("pwm_ds_timer: CNT_W must lie in 2..32");
   end
   if (N_CH < 1) begin : g_bad_ch
      $error("pwm_ds_timer: at least one channel is required");
   end
   if ((MIN_TOP >> CNT_W) != 0) begin : g_bad_min
      $error("pwm_ds_timer: MIN_TOP does not fit the counter");
   end
   if (ADDR_W < $clog2(N_CH + 1) || ADDR_W < 1) begin : g_bad_addr
      $error("pwm_ds_timer: ADDR_W too narrow for the register set");
   end

   logic [CNT_W-1:0]           act_top;
   logic [N_CH-1:0][CNT_W-1:0] act_cmp;
   logic [CNT_W-1:0]           top_sel;
   logic                       at_bottom;
   logic                       at_peak;
   logic                       next_up;
   logic [N_CH-1:0]            hit;
   logic [N_FLG-1:0]           flg_set;

   pwm_ds_regs #(
      .CNT_W (CNT_W),
      .N_CH  (N_CH),
      .ADDR_W(ADDR_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .load   (tick && at_bottom),
      .act_top(act_top),
      .act_cmp(act_cmp)
   );

   assign top_sel = top_src ? act_cmp[0] : act_top;

   pwm_ds_counter #(
      .CNT_W  (CNT_W),
      .MIN_TOP(MIN_TOP)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .top_sel  (top_sel),
      .count    (count),
      .at_bottom(at_bottom),
      .at_peak  (at_peak),
      .next_up  (next_up)
   );

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      pwm_ds_channel #(
         .CNT_W(CNT_W)
      ) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .count  (count),
         .cmp    (act_cmp[ch]),
         .next_up(next_up),
         .mode   (out_mode[2*ch +: 2]),
         .hit    (hit[ch]),
         .pin    (pwm_out[ch])
      );
      assign flg_set[FLG_CMP0 + ch] = hit[ch];
   end

   assign flg_set[FLG_WRAP] = tick && at_bottom;
   assign flg_set[FLG_PEAK] = tick && at_peak && !top_src;

   pwm_ds_flags #(
      .N_FLG(N_FLG)
   ) u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (flg_set),
      .clr  (flag_clr),
      .flags(flags)
   );

endmodule

// File: rtl/pwm_ds_chk.sv
module pwm_ds_chk #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned N_CH  = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       tick,
   input logic                       top_src,
   input logic [CNT_W-1:0]           count,
   input logic [N_CH+1:0]            flags,
   input logic [N_CH-1:0]            pwm_out,
   input logic [2*N_CH-1:0]          out_mode,
   input logic [CNT_W-1:0]           act_top,
   input logic [N_CH-1:0][CNT_W-1:0] act_cmp,
   input logic                       at_peak
);

   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (count == $past(count) + CNT_W'(1)) || (count == $past(count) - CNT_W'(1)));

   p_peak_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && at_peak) |=> (count == $past(count) - CNT_W'(1)));

   p_bottom_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == '0) |=> (count == CNT_W'(1)));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> (count == $past(count)));

   p_load_at_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && count == '0) |=> $stable(act_top));

   p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == '0) |=> flags[0]);

   p_peak_flag_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (top_src && !flags[1]) |=> !flags[1]);

   for (genvar i = 0; i < N_CH; i++) begin : g_chan
      p_cmp_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && count == act_cmp[i]) |=> flags[2+i]);

      p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (out_mode[2*i +: 2] == 2'd0 || out_mode[2*i +: 2] == 2'd1) |-> !pwm_out[i]);
   end

endmodule

bind pwm_ds_timer pwm_ds_chk #(
   .CNT_W(CNT_W),
   .N_CH (N_CH)
) u_pwm_ds_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .top_src (top_src),
   .count   (count),
   .flags   (flags),
   .pwm_out (pwm_out),
   .out_mode(out_mode),
   .act_top (act_top),
   .act_cmp (act_cmp),
   .at_peak (at_peak)
);

// File: tb/test_pwm_ds_timer.sv
module test_pwm_ds_timer;

   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          top_src = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [3:0]    out_mode = 4'b1110;
   logic [3:0]    flag_clr = '0;
   logic [W-1:0]  count;
   logic [3:0]    flags;
   logic [1:0]    pwm_out;

   always #4 clk = ~clk;

   pwm_ds_timer i_pwm_ds_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .top_src (top_src),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .out_mode(out_mode),
      .flag_clr(flag_clr),
      .count   (count),
      .flags   (flags),
      .pwm_out (pwm_out)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic [W-1:0] cnt;
      logic [3:0]   flg;
      logic [1:0]   pin;
      logic [3:0]   mode;
   } exp_t;

   exp_t sb_q[$];

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   function automatic logic pin_of(input logic [1:0] md, input logic lvl);
      if (md == 2'd2) return lvl;
      if (md == 2'd3) return !lvl;
      return 1'b0;
   endfunction

   function automatic string mode_tag(input logic [1:0] md);
      if (md == 2'd2) return "R9";
      if (md == 2'd3) return "R10";
      return "R11";
   endfunction

   // Predictor: builds the expected state from the requirements and queues it.
   int          m_cnt;
   bit          m_up;
   logic [W-1:0] m_stop, m_atop;
   logic [W-1:0] m_scmp [2];
   logic [W-1:0] m_acmp [2];
   logic [3:0]  m_flg;
   logic [1:0]  m_lvl;

   always @(posedge clk or negedge rst_n) begin
      int   eff;
      bit   nd;
      logic [3:0] setv;
      exp_t e;
      if (!rst_n) begin
         m_cnt = 0; m_up = 1'b0;
         m_stop = '1; m_atop = '1;
         for (int c = 0; c < 2; c++) begin m_scmp[c] = '0; m_acmp[c] = '0; end
         m_flg = '0; m_lvl = '0;
         sb_q.delete();
      end else begin
         eff = top_src ? int'(m_acmp[0]) : int'(m_atop);
         if (eff < 3) eff = 3;
         setv = '0;
         if (tick) begin
            if (m_cnt == 0) begin nd = 1'b1; setv[0] = 1'b1; end
            else if (m_up && m_cnt >= eff) begin nd = 1'b0; setv[1] = !top_src; end
            else nd = m_up;
            for (int c = 0; c < 2; c++) begin
               if (m_cnt == int'(m_acmp[c])) begin setv[2+c] = 1'b1; m_lvl[c] = !nd; end
            end
            if (m_cnt == 0) begin
               m_atop = m_stop;
               for (int c = 0; c < 2; c++) m_acmp[c] = m_scmp[c];
            end
            m_cnt = nd ? m_cnt + 1 : m_cnt - 1;
            m_up  = nd;
         end
         m_flg = (m_flg & ~flag_clr) | setv;
         if (wr_en) begin
            case (wr_addr)
               2'd0: m_stop = wr_data;
               2'd1: m_scmp[0] = wr_data;
               2'd2: m_scmp[1] = wr_data;
               default: ;
            endcase
         end
         e.cnt  = m_cnt[W-1:0];
         e.flg  = m_flg;
         e.mode = out_mode;
         e.pin  = {pin_of(out_mode[3:2], m_lvl[1]), pin_of(out_mode[1:0], m_lvl[0])};
         sb_q.push_back(e);
      end
   end

   // Monitor: pops one expected item per cycle and compares it away from the edge.
   always @(posedge clk) begin
      exp_t e;
      #2;
      if (rst_n && sb_q.size() > 0) begin
         e = sb_q.pop_front();
         check("R1", "count", count, e.cnt);
         check("R6", "wrap flag", flags[0], e.flg[0]);
         check("R7", "limit flag", flags[1], e.flg[1]);
         check("R8", "compare flags", flags[3:2], e.flg[3:2]);
         check(mode_tag(e.mode[1:0]), "pwm ch0", pwm_out[0], e.pin[0]);
         check(mode_tag(e.mode[3:2]), "pwm ch1", pwm_out[1], e.pin[1]);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         finish_up();
      end
   end

   task automatic smp();
      @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_max(input int n, output int mx);
      mx = 0;
      repeat (n) begin
         smp();
         if (int'(count) > mx) mx = int'(count);
      end
   endtask

   task automatic clear_all();
      @(negedge clk); flag_clr = 4'hF;
      @(negedge clk); flag_clr = 4'h0;
   endtask

   initial begin
      int mx;
      logic [W-1:0] held;
      logic [3:0]   fsnap;

      // R13: reset state
      repeat (3) smp();
      check("R13", "reset count", count, 0);
      check("R13", "reset flags", flags, 0);
      check("R13", "reset pwm", pwm_out, 2'b10);

      @(negedge clk); rst_n = 1'b1;
      wr(2'd0, 16'd10);
      wr(2'd1, 16'd4);
      wr(2'd2, 16'd7);
      @(negedge clk); tick = 1'b1;
      run_max(60, mx);
      check("R3", "peak from limit register", mx, 10);

      // R2: no tick, no motion
      @(negedge clk); tick = 1'b0;
      smp(); held = count;
      repeat (5) smp();
      check("R2", "count held without tick", count, held);
      @(negedge clk);
      for (int k = 0; k < 40; k++) begin
         @(negedge clk); tick = ~tick;
      end
      @(negedge clk); tick = 1'b1;

      // R5: mid-period limit write waits for the next bottom
      do smp(); while (count != 16'd6);
      wr(2'd0, 16'd20);
      mx = 0;
      do begin smp(); if (int'(count) > mx) mx = int'(count); end while (count != 0);
      check("R5", "peak of current period", mx, 10);
      run_max(50, mx);
      check("R5", "peak after reload", mx, 20);

      // R3 / R7: limit from channel 0 compare
      wr(2'd1, 16'd12);
      @(negedge clk); top_src = 1'b1;
      clear_all();
      run_max(40, mx);
      run_max(30, mx);
      check("R3", "peak from channel 0 compare", mx, 12);
      check("R7", "limit flag quiet in compare mode", flags[1], 0);
      check("R8", "channel 0 hit at limit", flags[2], 1);

      // R4: limit below minimum
      @(negedge clk); top_src = 1'b0;
      wr(2'd0, 16'd1);
      run_max(80, mx);
      run_max(20, mx);
      check("R4", "clamped peak", mx, 3);

      // R8: compare above limit never hits
      wr(2'd2, 16'd50);
      run_max(20, mx);
      clear_all();
      run_max(20, mx);
      check("R8", "ch1 compare above limit", flags[3], 0);
      check("R8", "ch0 compare above limit", flags[2], 0);
      check("R6", "wrap flag set", flags[0], 1);

      // R9 / R10: compare at bottom and at limit
      wr(2'd0, 16'd8);
      wr(2'd1, 16'd0);
      wr(2'd2, 16'd8);
      @(negedge clk); out_mode = 4'b1010;
      run_max(40, mx);
      for (int k = 0; k < 16; k++) begin
         smp();
         check("R9", "direct outputs at turning points", pwm_out, 2'b10);
      end
      @(negedge clk); out_mode = 4'b1111;
      for (int k = 0; k < 8; k++) begin
         smp();
         check("R10", "complemented outputs", pwm_out, 2'b01);
      end

      // R11: idle modes
      @(negedge clk); out_mode = 4'b0100;
      for (int k = 0; k < 8; k++) begin
         smp();
         check("R11", "idle outputs low", pwm_out, 2'b00);
      end

      // R12: write-one-to-clear
      @(negedge clk); tick = 1'b0;
      smp(); fsnap = flags;
      check("R12", "wrap flag present before clear", fsnap[0], 1);
      @(negedge clk); flag_clr = 4'b0000;
      smp();
      check("R12", "zero mask leaves flags", flags, fsnap);
      @(negedge clk); flag_clr = 4'b0001;
      @(negedge clk); flag_clr = 4'b0000;
      smp();
      check("R12", "one clears only its bit", flags, fsnap & 4'b1110);
      @(negedge clk); tick = 1'b1;
      do smp(); while (count != 0);
      @(negedge clk); flag_clr = 4'b0001;
      @(negedge clk); flag_clr = 4'b0000;
      smp();
      check("R12", "set wins over clear", flags[0], 1);

      repeat (3) smp();
      done = 1'b1;
      finish_up();
   end

endmodule